// File: doc/BRIEF.md
# Switch Debouncer with Fast Release

This block turns a noisy mechanical switch level into a clean one-bit signal. The raw level first crosses a short chain of flip-flops that brings it into the clock domain. A small three-state machine then looks at the synchronized samples. The clean level goes high only after two high samples in a row. It goes low as soon as one low sample arrives. A press therefore has to prove itself, while a release is acted on at once.

The machine moves between three codes: idle (00), armed (01) and held (10). Idle goes to armed on a high sample. Armed goes to held on a high sample. Any low sample sends every state back to idle. The fourth code, 11, cannot be reached, and the next-state logic sends it to idle anyway. The clean output is a flip-flop loaded with "next state is held", so it only changes on a clock edge. The block has no data stream, so every pin is a plain level.

Top module: `switch_debouncer`

## Requirements
- R1: A synchronous active-high reset sets the clean output to 0 at the first rising edge that samples reset high. The output stays 0 while reset is held. The synchronizer flops are also cleared, so input levels seen during reset are treated as low.
- R2: The raw input passes through SYNC_STAGES flip-flops (default 2) before the state logic sees it. With the default, a raw level sampled at rising edge n is used by the state register at edge n+2.
- R3: The clean output rises only after two consecutive synchronized high samples. If raw goes high and stays high, the clean output is 1 after the fourth rising edge, counting the edge that first samples the high level.
- R4: A raw high pulse that lasts exactly one clock cycle never sets the clean output.
- R5: A raw high pulse that lasts exactly two clock cycles sets the clean output for exactly one cycle.
- R6: While the clean output is 1, a single low sample clears it after the third rising edge, counting the edge that samples the low. A one-cycle low dip with high on both sides clears the output for exactly two cycles before it returns to 1.
- R7: While raw stays high, the clean output stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sw_raw | input | 1 | Raw switch level; may bounce and need not be synchronous |
| sw_clean | output | 1 | Debounced level, driven straight from a register |

## Verification
With default parameters, the clean output after rising edge m equals the logical AND of the raw samples taken at edges m-2 and m-3. Samples taken during reset count as low. Each time the driver applies a raw level, it pushes the expected output for two edges later into a queue. A monitor on the falling clock edge compares the output only when its edge count equals the due edge of the item at the head of the queue, so each result is checked in exactly the cycle it is due. Before a reset is applied, the queue is allowed to empty, and the reset result is then checked one edge after reset is sampled.

// File: rtl/sw_debounce_pkg.sv
package sw_debounce_pkg;

  // Codes of the debounce machine; 2'b11 is not used.
  typedef enum logic [1:0] {
    SW_IDLE  = 2'b00,
    SW_ARMED = 2'b01,
    SW_HELD  = 2'b10
  } sw_state_e;

  localparam int SW_STATE_W = 2;

endpackage

// File: rtl/sw_sync_chain.sv
module sw_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  // Chain of flops; stage 0 samples the asynchronous level.
  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end

        // R2: each stage carries the previous stage's value one edge later.
        a_r2_stage_shift: assert property (@(posedge clk) disable iff (rst)
          chain[i] == $past(chain[i-1]));
      end
    end
  endgenerate

  assign dout = chain[LAST];

endmodule

// File: rtl/sw_debounce_fsm.sv
module sw_debounce_fsm
  import sw_debounce_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sample,
  output logic clean
);

  sw_state_e state_q;
  sw_state_e state_d;
  logic      clean_q;

  // A press needs two high samples; any low sample releases at once.
  always_comb begin
    case (state_q)
      SW_IDLE:  state_d = sample ? SW_ARMED : SW_IDLE;
      SW_ARMED: state_d = sample ? SW_HELD  : SW_IDLE;
      SW_HELD:  state_d = sample ? SW_HELD  : SW_IDLE;
      default:  state_d = SW_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SW_IDLE;
      clean_q <= 1'b0;
    end else begin
      state_q <= state_d;
      clean_q <= (state_d == SW_HELD);
    end
  end

  assign clean = clean_q;

  // R1: reset leaves the machine idle with the output low.
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (state_q == SW_IDLE && !clean_q));

  // R3: a rising output is preceded by two high samples.
  a_r3_rise_two_highs: assert property (@(posedge clk) disable iff (rst)
    $rose(clean_q) |-> ($past(sample) && $past(sample, 2)));

  // R3: idle can never reach the output-high state in one step.
  a_r3_no_skip: assert property (@(posedge clk) disable iff (rst)
    (state_q == SW_IDLE) |=> !clean_q);

  // R6: a single low sample while high releases the output.
  a_r6_fast_release: assert property (@(posedge clk) disable iff (rst)
    (clean_q && !sample) |=> !clean_q);

  // R7: a high sample keeps a high output high.
  a_r7_hold_high: assert property (@(posedge clk) disable iff (rst)
    (clean_q && sample) |=> clean_q);

endmodule

// File: rtl/switch_debouncer.sv
module switch_debouncer #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sw_raw,
  output logic sw_clean
);

  logic sw_synced;

  sw_sync_chain #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (sw_raw),
    .dout (sw_synced)
  );

  sw_debounce_fsm u_fsm (
    .clk    (clk),
    .rst    (rst),
    .sample (sw_synced),
    .clean  (sw_clean)
  );

endmodule

// File: tb/sim_switch_debouncer.sv
module sim_switch_debouncer;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    int    due;
    logic  val;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic raw = 1'b0;
  logic clean;

  int   edge_cnt = 0;
  int   n_checks = 0;
  int   n_fail   = 0;
  logic prev_r   = 1'b0;
  exp_t sb_q[$];

  switch_debouncer u0 (
    .clk      (clk),
    .rst      (rst),
    .sw_raw   (raw),
    .sw_clean (clean)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  task automatic check(input logic act, input logic expv, input string tag);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s at edge %0d: clean=%b expected=%b", tag, edge_cnt, act, expv);
    end
  endtask

  // Driver: apply one raw level; the output is due two edges after it is sampled.
  task automatic step(input logic r, input string tag);
    exp_t e;
    @(negedge clk);
    raw = r;
    e.due = edge_cnt + 3;
    e.val = r & prev_r;
    e.tag = tag;
    sb_q.push_back(e);
    prev_r = r;
  endtask

  task automatic steps(input logic r, input int n, input string tag);
    for (int i = 0; i < n; i++) step(r, tag);
  endtask

  task automatic drain;
    while (sb_q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: compare when the head item falls due.
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due <= edge_cnt) begin
      exp_t e;
      e = sb_q.pop_front();
      check(clean, e.val, e.tag);
    end
  end

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    // R1: reset state
    rst = 1'b1;
    raw = 1'b1;
    repeat (3) @(negedge clk);
    check(clean, 1'b0, "R1 reset");
    @(negedge clk);
    raw = 1'b0;
    rst = 1'b0;
    prev_r = 1'b0;

    steps(1'b0, 3, "R1 idle after reset");
    // R2 / R3: steady press reaches high on the fourth edge
    steps(1'b1, 8, "R3 steady press");
    // R7: high raw keeps clean high
    steps(1'b1, 6, "R7 hold");
    // R6: release takes effect on one low sample
    steps(1'b0, 5, "R6 release");
    // R4: one-cycle high pulses
    step(1'b1, "R4 single high pulse");
    steps(1'b0, 4, "R4 single high pulse");
    step(1'b1, "R4 single high pulse");
    step(1'b0, "R4 single high pulse");
    step(1'b1, "R4 single high pulse");
    steps(1'b0, 4, "R4 single high pulse");
    // R5: two-cycle pulse gives one cycle of high output
    steps(1'b1, 2, "R5 double pulse");
    steps(1'b0, 5, "R5 double pulse");
    // R6: one-cycle low dip while held
    steps(1'b1, 6, "R6 dip");
    step(1'b0, "R6 dip");
    steps(1'b1, 6, "R6 dip");
    steps(1'b0, 4, "R6 dip");
    // R2: latency of a lone press/release edge
    steps(1'b1, 5, "R2 latency");
    steps(1'b0, 4, "R2 latency");
    // R3: bouncing input from a pseudo-random pattern
    lfsr = 16'hACE1;
    for (int i = 0; i < 200; i++) begin
      step(lfsr[0] | lfsr[3], "R3 bounce");
      lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
    end
    steps(1'b1, 6, "R7 hold");
    drain();

    // R1: reset while the output is high
    check(clean, 1'b1, "R7 before reset");
    rst = 1'b1;
    @(negedge clk);
    check(clean, 1'b0, "R1 mid-run reset");
    @(negedge clk);
    check(clean, 1'b0, "R1 reset held");
    raw = 1'b0;
    rst = 1'b0;
    prev_r = 1'b0;
    steps(1'b1, 6, "R3 press after reset");
    steps(1'b0, 4, "R6 release after reset");
    drain();

    summary();
    $finish;
  end

endmodule